// File: doc/BRIEF.md
# Coder Job Control and Interrupt Registers

This block is the host-facing control point of an entropy coder/decoder engine. The host writes a command word to start a job, to start a RAM initialisation, or to open the context table RAM for direct access. The same command word also picks the stopping mode. In hold mode the job stops after a programmed number of lines and waits to be resumed. In run-out mode the job continues until the engine reports that all data has been drained or consumed.

The engine reports back through single-cycle pulses: one per line, end of data, initialisation finished, marker found, and 0xFF byte emitted. It also drives a level that says its data buffer can be accessed. The block folds these reports into a read-only status word. It masks the status sources through an enable register and drives one active-high interrupt line.

A hold-mode stop raises the stop/end interrupt source but leaves the done flag clear. An overflow of the 0xFF byte counter is flagged but does not stop the job.

Top module: `coder_job_ctl`

## Requirements
- R1: After reset, the status word (address 2) reads 0 when the buffer-ready input is low. The enable register (address 3) reads 0, and irq, job_run and ctx_ram_open are all low.
- R2: Writing address 0 with bit 0 (go) set raises job_run on the next cycle. The same write clears status bits 0 (done), 2 (marker) and 4 (overflow), the pause state in bit 5, and the latched stop/end event.
- R3: In hold mode (command bit 2 = 1 at the go write), job_run drops on the clock that takes the Nth eng_line pulse, where N is the value at address 1. Status bit 5 then reads 1, bit 0 stays 0, and the stop/end event is latched. A later go write resumes the job and restarts the line count.
- R4: While job_run is high, an eng_end pulse drops job_run, sets status bit 0 to 1 and bit 5 to 0, and latches the stop/end event. In run-out mode eng_line pulses never stop the job. eng_end has no effect while job_run is low.
- R5: Writing address 0 with bit 1 (init) set raises init_busy and clears status bit 0. The next eng_init_done pulse drops init_busy and sets status bit 0.
- R6: Status bit 1 follows the eng_buf_ready input.
- R7: An eng_marker pulse while job_run is high sets status bit 2 until the next go write. A pulse while job_run is low is ignored.
- R8: While job_run is high, the block counts eng_ff_byte cycles in an 8-bit counter. The 256th such byte after a go write sets status bit 4, and job_run stays high.
- R9: Status bit 3 and the irq output are high exactly when at least one enabled source is set. The enable bits are: bit 0 for the stop/end event, bit 1 for buffer ready, bit 2 for marker, and bit 3 for overflow.
- R10: Command bit 3 drives ctx_ram_open. The output holds that value until the next write to address 0.
- R11: Address 1 reads back the last line count written to it. Address 3 reads back only the low 4 bits written to it. Address 0 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 2 | Register address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data for host_addr (combinational) |
| eng_line | input | 1 | One line processed |
| eng_end | input | 1 | All data drained or consumed |
| eng_init_done | input | 1 | RAM initialisation finished |
| eng_buf_ready | input | 1 | Data buffer accessible |
| eng_marker | input | 1 | Marker code found while decoding |
| eng_ff_byte | input | 1 | A 0xFF byte was emitted while coding |
| job_run | output | 1 | Job in progress, engine may run |
| init_busy | output | 1 | RAM initialisation in progress |
| ctx_ram_open | output | 1 | Host access to the context table RAM granted |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest condition to reach from the ports is the overflow flag. It needs 256 consecutive counted 0xFF bytes inside a single job, with no go write in between. The bench holds eng_ff_byte high for exactly 255 clocks and checks that the flag is still clear. It then adds one more single-cycle pulse and checks that the flag has set and job_run is still high.

The pause-then-resume path is the other hard case. The bench counts lines up to the programmed target twice, with a resume in between. It then shows that an end pulse arriving while paused leaves the status word unchanged.

// File: rtl/coder_job_ctl_pkg.sv
package coder_job_ctl_pkg;
  // register addresses
  localparam int ADDR_CMD   = 0;
  localparam int ADDR_LINES = 1;
  localparam int ADDR_STAT  = 2;
  localparam int ADDR_IEN   = 3;

  // command word bits
  localparam int CMD_GO   = 0;
  localparam int CMD_INIT = 1;
  localparam int CMD_HOLD = 2;
  localparam int CMD_CTX  = 3;

  localparam int NSRC   = 4;
  localparam int STAT_W = 6;

  // interrupt sources, bit order matches the enable register
  typedef struct packed {
    logic ovf;
    logic marker;
    logic ready;
    logic evt;
  } src_t;

  function automatic logic irq_merge(input src_t s, input logic [NSRC-1:0] en);
    return |(s & en);
  endfunction

  function automatic logic [STAT_W-1:0] pack_status(input logic done, input logic ready,
                                                    input logic marker, input logic req,
                                                    input logic ovf, input logic paused);
    return {paused, ovf, req, marker, ready, done};
  endfunction
endpackage

// File: rtl/coder_job_regs.sv
module coder_job_regs
  import coder_job_ctl_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              go_wr,
  output logic              init_wr,
  output logic              hold_mode,
  output logic              ctx_open,
  output logic [NSRC-1:0]   ien,
  output logic [DATA_W-1:0] line_target
);
  logic cmd_sel;
  assign cmd_sel = host_wr && (host_addr == ADDR_W'(ADDR_CMD));
  assign go_wr   = cmd_sel && host_wdata[CMD_GO];
  assign init_wr = cmd_sel && host_wdata[CMD_INIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_mode   <= 1'b0;
      ctx_open    <= 1'b0;
      ien         <= '0;
      line_target <= '0;
    end else if (host_wr) begin
      case (host_addr)
        ADDR_W'(ADDR_CMD): begin
          hold_mode <= host_wdata[CMD_HOLD];
          ctx_open  <= host_wdata[CMD_CTX];
        end
        ADDR_W'(ADDR_LINES): line_target <= host_wdata;
        ADDR_W'(ADDR_IEN):   ien <= host_wdata[NSRC-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/coder_job_seq.sv
module coder_job_seq #(
  parameter int LINE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_wr,
  input  logic              init_wr,
  input  logic              hold_mode,
  input  logic [LINE_W-1:0] line_target,
  input  logic              eng_line,
  input  logic              eng_end,
  input  logic              eng_init_done,
  output logic              job_run,
  output logic              init_busy,
  output logic              done,
  output logic              paused,
  output logic              evt,
  output logic              pause_evt,
  output logic              end_evt,
  output logic              init_fin
);
  logic [LINE_W-1:0] cnt_q;

  function automatic logic reached(input logic [LINE_W-1:0] c, input logic [LINE_W-1:0] t);
    return (c + 1'b1) == t;
  endfunction

  assign end_evt   = job_run & eng_end & ~go_wr;
  assign pause_evt = job_run & eng_line & hold_mode & ~eng_end & ~go_wr
                     & reached(cnt_q, line_target);
  assign init_fin  = init_busy & eng_init_done & ~init_wr & ~go_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      job_run   <= 1'b0;
      init_busy <= 1'b0;
      done      <= 1'b0;
      paused    <= 1'b0;
      evt       <= 1'b0;
      cnt_q     <= '0;
    end else begin
      if (go_wr) begin
        job_run <= 1'b1;
        done    <= 1'b0;
        evt     <= 1'b0;
        paused  <= 1'b0;
        cnt_q   <= '0;
      end else if (end_evt) begin
        job_run <= 1'b0;
        done    <= 1'b1;
        evt     <= 1'b1;
        paused  <= 1'b0;
      end else if (pause_evt) begin
        job_run <= 1'b0;
        evt     <= 1'b1;
        paused  <= 1'b1;
      end else if (job_run && eng_line) begin
        cnt_q <= cnt_q + 1'b1;
      end
      if (init_wr) begin
        init_busy <= 1'b1;
        done      <= 1'b0;
        evt       <= 1'b0;
        paused    <= 1'b0;
      end else if (init_fin) begin
        init_busy <= 1'b0;
        done      <= 1'b1;
        evt       <= 1'b1;
        paused    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/coder_job_flags.sv
module coder_job_flags #(
  parameter int FF_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go_wr,
  input  logic job_run,
  input  logic eng_marker,
  input  logic eng_ff_byte,
  output logic marker,
  output logic ovf
);
  localparam logic [FF_W-1:0] FF_MAX = '1;
  logic [FF_W-1:0] ff_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      marker <= 1'b0;
      ovf    <= 1'b0;
      ff_cnt <= '0;
    end else if (go_wr) begin
      marker <= 1'b0;
      ovf    <= 1'b0;
      ff_cnt <= '0;
    end else begin
      if (job_run && eng_marker) marker <= 1'b1;
      if (job_run && eng_ff_byte) begin
        if (ff_cnt == FF_MAX) ovf <= 1'b1;
        else                  ff_cnt <= ff_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/coder_job_ctl.sv
module coder_job_ctl
  import coder_job_ctl_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2,
  parameter int FF_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              eng_line,
  input  logic              eng_end,
  input  logic              eng_init_done,
  input  logic              eng_buf_ready,
  input  logic              eng_marker,
  input  logic              eng_ff_byte,
  output logic              job_run,
  output logic              init_busy,
  output logic              ctx_ram_open,
  output logic              irq
);
  localparam int LINE_W = DATA_W;

  logic              go_wr, init_wr, hold_mode;
  logic [NSRC-1:0]   ien;
  logic [LINE_W-1:0] line_target;
  logic              done, paused, evt, pause_evt, end_evt, init_fin;
  logic              marker, ovf;
  src_t              src;
  logic [STAT_W-1:0] status;

  coder_job_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) regs_i (
    .clk, .rst_n, .host_wr, .host_addr, .host_wdata,
    .go_wr, .init_wr, .hold_mode, .ctx_open(ctx_ram_open), .ien, .line_target
  );

  coder_job_seq #(.LINE_W(LINE_W)) seq_i (
    .clk, .rst_n, .go_wr, .init_wr, .hold_mode, .line_target,
    .eng_line, .eng_end, .eng_init_done,
    .job_run, .init_busy, .done, .paused, .evt, .pause_evt, .end_evt, .init_fin
  );

  coder_job_flags #(.FF_W(FF_W)) flags_i (
    .clk, .rst_n, .go_wr, .job_run, .eng_marker, .eng_ff_byte, .marker, .ovf
  );

  assign src    = '{ovf: ovf, marker: marker, ready: eng_buf_ready, evt: evt};
  assign irq    = irq_merge(src, ien);
  assign status = pack_status(done, eng_buf_ready, marker, irq, ovf, paused);

  always_comb begin
    case (host_addr)
      ADDR_W'(ADDR_LINES): host_rdata = line_target;
      ADDR_W'(ADDR_STAT):  host_rdata = DATA_W'(status);
      ADDR_W'(ADDR_IEN):   host_rdata = DATA_W'(ien);
      default:             host_rdata = '0;
    endcase
  end
endmodule

// File: rtl/coder_job_ctl_chk.sv
module coder_job_ctl_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] host_addr,
  input logic [DATA_W-1:0] host_rdata,
  input logic [3:0]        ien,
  input logic              irq,
  input logic              job_run,
  input logic              init_busy,
  input logic              done,
  input logic              paused,
  input logic              marker,
  input logic              ovf,
  input logic              go_wr,
  input logic              pause_evt,
  input logic              end_evt,
  input logic              init_fin
);
  assert_go_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    go_wr |=> (job_run && !done && !marker && !ovf && !paused));

  assert_pause_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_evt && !init_fin) |=> (!job_run && paused && !done));

  assert_end_sets_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (end_evt && !init_fin) |=> (!job_run && done && !paused));

  assert_init_finish_R5: assert property (@(posedge clk) disable iff (!rst_n)
    init_fin |=> (done && !init_busy));

  assert_ovf_in_job_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $past(job_run));

  assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == 4'd0) |-> !irq);

  assert_irq_in_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr == ADDR_W'(2)) |-> (host_rdata[3] == irq));
endmodule

bind coder_job_ctl coder_job_ctl_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rdata(host_rdata),
  .ien(ien), .irq(irq), .job_run(job_run), .init_busy(init_busy),
  .done(done), .paused(paused), .marker(marker), .ovf(ovf),
  .go_wr(go_wr), .pause_evt(pause_evt), .end_evt(end_evt), .init_fin(init_fin)
);

// File: tb/coder_job_ctl_tb_top.sv
module coder_job_ctl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [1:0]  host_addr = 2'd0;
  logic [15:0] host_wdata = 16'd0;
  logic [15:0] host_rdata;
  logic eng_line = 0, eng_end = 0, eng_init_done = 0;
  logic eng_buf_ready = 0, eng_marker = 0, eng_ff_byte = 0;
  logic job_run, init_busy, ctx_ram_open, irq;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  coder_job_ctl dut_i (
    .clk, .rst_n, .host_wr, .host_addr, .host_wdata, .host_rdata,
    .eng_line, .eng_end, .eng_init_done, .eng_buf_ready, .eng_marker, .eng_ff_byte,
    .job_run, .init_busy, .ctx_ram_open, .irq
  );

  // {write, addr, data, expected read}
  localparam logic [34:0] TBL [9] = '{
    {1'b1, 2'd3, 16'h000F, 16'h0000},
    {1'b0, 2'd3, 16'h0000, 16'h000F},
    {1'b1, 2'd3, 16'hFFF5, 16'h0000},
    {1'b0, 2'd3, 16'h0000, 16'h0005},
    {1'b1, 2'd1, 16'h1234, 16'h0000},
    {1'b0, 2'd1, 16'h0000, 16'h1234},
    {1'b1, 2'd1, 16'h0003, 16'h0000},
    {1'b0, 2'd1, 16'h0000, 16'h0003},
    {1'b0, 2'd0, 16'h0000, 16'h0000}
  };

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    host_addr = a;
    #1;
    d = host_rdata;
  endtask

  task automatic stat(input logic [15:0] exp, input string tag);
    logic [15:0] v;
    rd(2'd2, v);
    chk(v, exp, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    stat(16'h0000, "R1 status");
    rd(2'd3, v); chk(v, 16'h0000, "R1 enable");
    chk({12'd0, irq, job_run, ctx_ram_open, init_busy}, 16'h0000, "R1 outputs");

    // R11 register table
    for (int i = 0; i < 9; i++) begin
      if (TBL[i][34]) wr(TBL[i][33:32], TBL[i][31:16]);
      else begin
        @(negedge clk);
        rd(TBL[i][33:32], v);
        chk(v, TBL[i][15:0], "R11 readback");
      end
    end
    wr(2'd3, 16'h0000);

    // R10 context RAM access
    wr(2'd0, 16'h0008);
    chk(16'(ctx_ram_open), 16'h1, "R10 open");
    repeat (3) @(negedge clk);
    chk(16'(ctx_ram_open), 16'h1, "R10 held");
    wr(2'd0, 16'h0000);
    chk(16'(ctx_ram_open), 16'h0, "R10 closed");

    // R6 buffer ready and R9 masking
    eng_buf_ready = 1'b1;
    stat(16'h0002, "R6 ready masked");
    chk(16'(irq), 16'h0, "R9 masked irq");
    wr(2'd3, 16'h0002);
    stat(16'h000A, "R9 ready enabled");
    chk(16'(irq), 16'h1, "R9 irq");
    eng_buf_ready = 1'b0;
    stat(16'h0000, "R6 ready low");
    wr(2'd3, 16'h0000);

    // R5 initialisation
    wr(2'd0, 16'h0002);
    chk(16'(init_busy), 16'h1, "R5 busy");
    stat(16'h0000, "R5 not done");
    @(negedge clk); eng_init_done = 1'b1; @(negedge clk); eng_init_done = 1'b0;
    chk(16'(init_busy), 16'h0, "R5 idle");
    stat(16'h0001, "R5 done");
    wr(2'd3, 16'h0001);
    stat(16'h0009, "R9 event enabled");

    // R2 start, R4 run-out mode
    wr(2'd0, 16'h0001);
    chk(16'(job_run), 16'h1, "R2 run");
    stat(16'h0000, "R2 cleared");
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); eng_line = 1'b1; @(negedge clk); eng_line = 1'b0;
    end
    chk(16'(job_run), 16'h1, "R4 lines ignored");
    @(negedge clk); eng_end = 1'b1; @(negedge clk); eng_end = 1'b0;
    chk(16'(job_run), 16'h0, "R4 stopped");
    stat(16'h0009, "R4 end status");
    @(negedge clk); eng_marker = 1'b1; @(negedge clk); eng_marker = 1'b0;
    stat(16'h0009, "R7 idle marker ignored");

    // R3 hold mode with resume
    wr(2'd0, 16'h0005);
    stat(16'h0000, "R3 started");
    for (int k = 0; k < 2; k++) begin
      @(negedge clk); eng_line = 1'b1; @(negedge clk); eng_line = 1'b0;
    end
    chk(16'(job_run), 16'h1, "R3 before target");
    @(negedge clk); eng_line = 1'b1; @(negedge clk); eng_line = 1'b0;
    chk(16'(job_run), 16'h0, "R3 paused");
    stat(16'h0028, "R3 pause status");
    chk(16'(irq), 16'h1, "R9 pause irq");
    wr(2'd0, 16'h0005);
    chk(16'(job_run), 16'h1, "R3 resumed");
    chk(16'(irq), 16'h0, "R2 irq cleared");
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); eng_line = 1'b1; @(negedge clk); eng_line = 1'b0;
    end
    stat(16'h0028, "R3 second pause");
    @(negedge clk); eng_end = 1'b1; @(negedge clk); eng_end = 1'b0;
    stat(16'h0028, "R4 end while paused ignored");

    // R7 marker
    wr(2'd0, 16'h0001);
    @(negedge clk); eng_marker = 1'b1; @(negedge clk); eng_marker = 1'b0;
    stat(16'h0004, "R7 marker set");
    wr(2'd3, 16'h0004);
    stat(16'h000C, "R9 marker enabled");
    wr(2'd0, 16'h0001);
    stat(16'h0000, "R2 marker cleared");

    // R8 0xFF byte counter overflow
    wr(2'd3, 16'h0008);
    wr(2'd0, 16'h0001);
    @(negedge clk); eng_ff_byte = 1'b1;
    repeat (255) @(negedge clk);
    eng_ff_byte = 1'b0;
    stat(16'h0000, "R8 255 bytes no flag");
    @(negedge clk); eng_ff_byte = 1'b1; @(negedge clk); eng_ff_byte = 1'b0;
    stat(16'h0018, "R8 overflow");
    chk(16'(job_run), 16'h1, "R8 still running");
    wr(2'd0, 16'h0001);
    stat(16'h0000, "R2 overflow cleared");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule